// File: doc/BRIEF.md
# Strap-Latch and External Interrupt Front-End

This block owns four shared, active-low input pins that do two jobs over time. While the chip is in reset, the pins are boot straps. When reset is released, their synchronized value is captured once into a four-bit operating-mode register. The register holds that value until the next reset.

Outside reset, the same pins are four external interrupt request lines, A to D. Per-line configuration bits choose level-sensitive or falling-edge detection and enable or mask each line. The block sends one request bit per line to the core. It also raises wake-up indications for the two standby states: any enabled request ends WAIT, and only line A ends STOP.

Every pin passes through a two-flop synchronizer before it is used for mode capture or edge detection. An edge-mode request stays latched until the core acknowledges it. A level-mode request follows the synchronized pin.

Top module: `strap_irq_front`

## Requirements
- R1: While `rst_n` is low, `mode` reads 4'b0000.
- R2: On the first rising clock edge after `rst_n` goes high, `mode` takes the synchronized pin value, with bit i taken from `pin_n[i]` and line A as bit 0. Pin activity after that edge leaves `mode` unchanged until the next reset.
- R3: A line in level mode (`edge_sel[i]`=0) that is enabled drives `irq_req[i]` high while its pin is low. The output changes on the second rising edge after the pin changes.
- R4: A line in edge mode (`edge_sel[i]`=1) sets a pending flag on a falling pin edge. `irq_req[i]` rises on the third rising edge after the pin falls and stays high after the pin returns high.
- R5: A high `ack[i]` clears line i's pending flag at the next edge. If a new falling edge is detected in that same cycle, the flag stays set.
- R6: `line_en[i]`=0 forces `irq_req[i]` low. A pending flag latched while the line is masked is kept and appears once the line is enabled.
- R7: A rising pin edge, or a pin that stays low, never sets the pending flag again after it has been acknowledged.
- R8: `wake_stop` is high exactly when `in_stop` is high and `irq_req[0]` (line A) is high. Requests on lines B, C and D have no effect on it.
- R9: `wake_wait` is high exactly when `in_wait` is high and any `irq_req` bit is high.
- R10: No request is raised while reset is held or in the capture cycle. Straps held low through reset do not leave an edge-mode request behind after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_n | input | 4 | Shared strap / interrupt pins, active low |
| edge_sel | input | 4 | Per line: 1 = falling-edge, 0 = level |
| line_en | input | 4 | Per line: 1 = enabled, 0 = masked |
| ack | input | 4 | Per line: clears a latched edge request |
| in_stop | input | 1 | Core is in STOP |
| in_wait | input | 1 | Core is in WAIT |
| mode | output | 4 | Captured operating mode |
| irq_req | output | 4 | Request per line to the core |
| wake_stop | output | 1 | Leave STOP |
| wake_wait | output | 1 | Leave WAIT |

## Verification
An acknowledge and a fresh falling edge on the same edge-mode line can reach the pending flag at the same clock edge. The bench provokes this by raising `ack` exactly in the cycle before the third edge after the pin falls again, while the flag is already set. It judges the result by requiring the request to remain high, and then by showing that a lone acknowledge does clear it.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;

  // falling transition between consecutive synchronized samples (pins are active low)
  function automatic logic fall_seen(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction

  // a new event has priority over an acknowledge in the same cycle
  function automatic logic next_pend(input logic pend, input logic set_ev, input logic clr);
    return set_ev | (pend & ~clr);
  endfunction

  // request seen by the core for one line
  function automatic logic line_req(input logic en, input logic edge_mode,
                                    input logic pend, input logic pin_s);
    return en & (edge_mode ? pend : ~pin_s);
  endfunction

endpackage

// File: rtl/strap_irq_sync.sv
module strap_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // no reset: the chain must keep sampling straps while reset is held
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) stg[k] <= stg[k-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_mode_latch.sv
module strap_mode_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] strap_s,
  output logic [WIDTH-1:0] mode,
  output logic             armed
);
  logic [WIDTH-1:0] mode_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      mode_q  <= strap_s;
      armed_q <= 1'b0;
    end
  end

  assign mode  = mode_q;
  assign armed = armed_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_MODE_ZERO_RST: assert (mode_q == '0) else $error("mode nonzero in reset"); // R1
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> $stable(mode_q)); // R2
endmodule

// File: rtl/strap_irq_line.sv
module strap_irq_line
  import strap_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic en,
  input  logic ack,
  output logic req
);
  logic prev_q;
  logic pend_q;
  logic fall_w;
  logic set_w;

  always_ff @(posedge clk) prev_q <= pin_s;

  assign fall_w = fall_seen(prev_q, pin_s);
  assign set_w  = active & edge_mode & fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= next_pend(pend_q, set_w, ack);
  end

  assign req = active & line_req(en, edge_mode, pend_q, pin_s);

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (active && edge_mode && fall_w) |=> pend_q); // R4
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_w) |=> !pend_q); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !fall_w) |=> !pend_q); // R7
endmodule

// File: rtl/strap_irq_front.sv
module strap_irq_front #(
  parameter int                 NUM_LINES       = 4,
  parameter int                 SYNC_STAGES     = 2,
  parameter logic [NUM_LINES-1:0] STOP_WAKE_LINES = 4'b0001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pin_n,
  input  logic [3:0] edge_sel,
  input  logic [3:0] line_en,
  input  logic [3:0] ack,
  input  logic       in_stop,
  input  logic       in_wait,
  output logic [3:0] mode,
  output logic [3:0] irq_req,
  output logic       wake_stop,
  output logic       wake_wait
);
  localparam int MODE_W = NUM_LINES;

  logic [NUM_LINES-1:0] pin_s;
  logic                 armed;
  logic [NUM_LINES-1:0] req_w;

  strap_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_n),
    .q   (pin_s)
  );

  strap_mode_latch #(.WIDTH(MODE_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_s (pin_s),
    .mode    (mode),
    .armed   (armed)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    strap_irq_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (~armed),
      .pin_s     (pin_s[i]),
      .edge_mode (edge_sel[i]),
      .en        (line_en[i]),
      .ack       (ack[i]),
      .req       (req_w[i])
    );
  end

  assign irq_req   = req_w;
  assign wake_stop = in_stop & |(req_w & STOP_WAKE_LINES);
  assign wake_wait = in_wait & |req_w;

  AST_QUIET_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_req == '0)); // R10
  AST_STOP_IGNORES_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req[0]) |-> !wake_stop); // R8
endmodule

// File: tb/strap_irq_front_test.sv
module strap_irq_front_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_n, edge_sel, line_en, ack;
  logic       in_stop, in_wait;
  logic [3:0] mode, irq_req;
  logic       wake_stop, wake_wait;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_irq_front uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_sel(edge_sel),
    .line_en(line_en), .ack(ack), .in_stop(in_stop), .in_wait(in_wait),
    .mode(mode), .irq_req(irq_req), .wake_stop(wake_stop), .wake_wait(wake_wait)
  );

  // level-mode vectors: [15:12] pin_n, [11:8] line_en, [7] in_stop, [6] in_wait,
  // [5:2] expected irq_req, [1] expected wake_stop, [0] expected wake_wait
  localparam logic [15:0] VEC [7] = '{
    {4'b1111, 4'b1111, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0},
    {4'b1110, 4'b1111, 1'b1, 1'b0, 4'b0001, 1'b1, 1'b0},
    {4'b1101, 4'b1111, 1'b1, 1'b1, 4'b0010, 1'b0, 1'b1},
    {4'b0011, 4'b1111, 1'b0, 1'b1, 4'b1100, 1'b0, 1'b1},
    {4'b0000, 4'b0101, 1'b1, 1'b0, 4'b0101, 1'b1, 1'b0},
    {4'b0000, 4'b0000, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0},
    {4'b1010, 4'b1111, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; pin_n = 4'b1010; edge_sel = 4'b0000; line_en = 4'b1111;
    ack = 4'b0000; in_stop = 1'b0; in_wait = 1'b0;
    tick(5);
    chk("R1 mode zero in reset", {4'b0, mode}, 8'h00);
    chk("R10 no level request in reset", {4'b0, irq_req}, 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R2 mode captured", {4'b0, mode}, 8'h0A);

    // edge mode, line A
    edge_sel = 4'b1111; pin_n = 4'b1111; tick(3);
    pin_n = 4'b1110; tick(2);
    chk("R4 edge not yet visible", {4'b0, irq_req}, 8'h00);
    tick(1);
    chk("R4 edge latched", {4'b0, irq_req}, 8'h01);
    pin_n = 4'b1111; tick(3);
    chk("R4 held after pin high", {4'b0, irq_req}, 8'h01);
    in_stop = 1'b1; tick(1);
    chk("R8 line A wakes stop", {7'b0, wake_stop}, 8'h01);
    ack = 4'b0001; tick(1); ack = 4'b0000;
    chk("R5 ack clears", {4'b0, irq_req}, 8'h00);

    // line B: no stop wake, wait wake
    pin_n = 4'b1101; tick(3);
    chk("R8 line B no stop wake", {3'b0, irq_req, wake_stop}, {3'b0, 4'b0010, 1'b0});
    in_wait = 1'b1; tick(1);
    chk("R9 line B wakes wait", {7'b0, wake_wait}, 8'h01);
    pin_n = 4'b1111; tick(3);
    // collision: new fall reaches the flag in the same cycle as ack
    pin_n = 4'b1101; tick(2);
    ack = 4'b0010; tick(1); ack = 4'b0000;
    chk("R5 edge beats ack", {4'b0, irq_req}, 8'h02);
    ack = 4'b0010; tick(1); ack = 4'b0000;
    chk("R5 lone ack clears", {4'b0, irq_req}, 8'h00);
    pin_n = 4'b1111; tick(3);

    // masking keeps pending
    line_en = 4'b1011; pin_n = 4'b1011; tick(3);
    chk("R6 masked line silent", {4'b0, irq_req}, 8'h00);
    line_en = 4'b1111; tick(1);
    chk("R6 pending appears on enable", {4'b0, irq_req}, 8'h04);
    ack = 4'b0100; tick(1); ack = 4'b0000;
    pin_n = 4'b1111; tick(3);
    chk("R7 rising edge no request", {4'b0, irq_req}, 8'h00);
    pin_n = 4'b0111; tick(3);
    ack = 4'b1000; tick(1); ack = 4'b0000;
    tick(3);
    chk("R7 held-low no retrigger", {4'b0, irq_req}, 8'h00);
    pin_n = 4'b1111; tick(3);

    // level-mode table
    edge_sel = 4'b0000;
    for (int v = 0; v < 7; v++) begin
      pin_n = VEC[v][15:12]; line_en = VEC[v][11:8];
      in_stop = VEC[v][7]; in_wait = VEC[v][6];
      tick(3);
      chk($sformatf("R3 level vector %0d req", v), {4'b0, irq_req}, {4'b0, VEC[v][5:2]});
      chk($sformatf("R8 vector %0d wake_stop", v), {7'b0, wake_stop}, {7'b0, VEC[v][1]});
      chk($sformatf("R9 vector %0d wake_wait", v), {7'b0, wake_wait}, {7'b0, VEC[v][0]});
    end
    // level timing: visible on second edge
    pin_n = 4'b1111; line_en = 4'b1111; tick(3);
    pin_n = 4'b1011; tick(1);
    chk("R3 level not after one edge", {4'b0, irq_req}, 8'h00);
    tick(1);
    chk("R3 level after two edges", {4'b0, irq_req}, 8'h04);
    chk("R2 mode unchanged by pins", {4'b0, mode}, 8'h0A);

    // second reset: straps low, edge mode
    rst_n = 1'b0; pin_n = 4'b0000; edge_sel = 4'b1111; in_stop = 1'b0; in_wait = 1'b0;
    tick(1);
    chk("R1 mode cleared by reset", {4'b0, mode}, 8'h00);
    tick(4);
    rst_n = 1'b1; tick(1);
    chk("R2 mode captured zero", {4'b0, mode}, 8'h00);
    tick(5);
    chk("R10 no edge request from straps", {4'b0, irq_req}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule